// File: doc/BRIEF.md
# Segmentable Tapped Shift Register

This block is one channel of a serial delay line built from 64 storage stages, with four tap points after stages 16, 32, 48 and 64. Each tap point is a bidirectional pin. It is modelled as three signals: a data-out value, an output enable and a data-in value. A chip that needs two channels instantiates the block twice. Each channel has its own clock, data input and mode control.

A single mode input selects one of two modes. In chain mode the stages form one 64-stage serial path and all four taps drive out. In split mode the tap drivers are released. The first three tap inputs then feed the first stage of the second, third and fourth 16-stage segment, so the line becomes four independent 16-stage shifters. The stage 64 tap feeds no stage in either mode. A mode change applies at the next rising edge, and stored contents are kept across it. A synchronous active-high reset clears every stage.

Top module: `seg_shift_chain`

## Requirements
- R1: A rising clock edge with `rst` high clears all 64 stages, so all four bits of `tap_out` read 0 afterwards.
- R2: On every rising edge without reset, stage 1 captures `ser_in`, in both modes.
- R3: In chain mode (`split_mode` = 0), each stage s > 1 takes the old value of stage s-1. A bit captured at one edge appears on `tap_out[3]` after exactly 64 edges, and `tap_out[k]` (k = 0..3) always shows stage 16·(k+1).
- R4: While `split_mode` is 0, `tap_oe` is 4'b1111.
- R5: While `split_mode` is 1, `tap_oe` is 4'b0000.
- R6: In split mode, stages 17, 33 and 49 load `tap_in[0]`, `tap_in[1]` and `tap_in[2]` respectively, and no bit crosses from one 16-stage segment into the next.
- R7: The stage 64 tap feeds no stage. In split mode `tap_out[3]` still shows stage 64 of the fourth segment.
- R8: A mode change takes effect at the next rising edge. Stage contents are kept through the change and keep shifting by one stage per edge.
- R9: In chain mode `tap_in` has no effect on any stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge |
| rst | input | 1 | Synchronous active-high clear of all stages |
| ser_in | input | 1 | Serial data into stage 1 |
| split_mode | input | 1 | 0: one 64-stage chain, 1: four 16-stage segments |
| tap_in | input | 3 | Tap pin input values for taps 16, 32, 48 (segment inputs in split mode) |
| tap_out | output | 4 | Contents of stages 16, 32, 48, 64 |
| tap_oe | output | 4 | Tap driver enables, all high in chain mode |

## Verification
A single 1 is sent into a chain of zeros to check the 64-stage delay: an off-by-one stage count would show the pulse one edge early or late on `tap_out[3]`. In split mode, `tap_in` carries patterns different from `ser_in`. A design that left segment links connected, or that swapped the tap inputs, would show the neighbouring segment's data on the taps. The bench also switches modes in the middle of a stream and toggles `tap_in` during chain mode. These steps catch a design that loses or re-clears its contents on a mode change, or that lets tap inputs leak into the chain.

// File: rtl/segsr_pkg.sv
package segsr_pkg;
  typedef enum logic {
    MODE_CHAIN = 1'b0,
    MODE_SPLIT = 1'b1
  } seg_mode_e;
endpackage

// File: rtl/segsr_segment.sv
module segsr_segment #(
  parameter int SEG_LEN = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               d,
  output logic [SEG_LEN-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= {q[SEG_LEN-2:0], d};
  end

  // R8
  seg_shift_keep_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> q[SEG_LEN-1:1] == $past(q[SEG_LEN-2:0]));
endmodule

// File: rtl/segsr_feed_sel.sv
module segsr_feed_sel
  import segsr_pkg::*;
#(
  parameter int NUM_SEGS = 4
) (
  input  logic                ser_in,
  input  logic                split_mode,
  input  logic [NUM_SEGS-2:0] tap_in,
  input  logic [NUM_SEGS-2:0] tail_in,
  output logic [NUM_SEGS-1:0] seg_head
);
  seg_mode_e mode;
  assign mode = seg_mode_e'(split_mode);
  assign seg_head[0] = ser_in;

  for (genvar g = 1; g < NUM_SEGS; g++) begin : g_link
    assign seg_head[g] = (mode == MODE_SPLIT) ? tap_in[g-1] : tail_in[g-1];
  end
endmodule

// File: rtl/seg_shift_chain.sv
module seg_shift_chain
  import segsr_pkg::*;
#(
  parameter int SEG_LEN  = 16,
  parameter int NUM_SEGS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ser_in,
  input  logic                split_mode,
  input  logic [NUM_SEGS-2:0] tap_in,
  output logic [NUM_SEGS-1:0] tap_out,
  output logic [NUM_SEGS-1:0] tap_oe
);
  logic [NUM_SEGS-1:0] seg_head;
  logic [NUM_SEGS-1:0] seg_tail;
  logic [SEG_LEN-1:0]  seg_q [NUM_SEGS];

  segsr_feed_sel #(.NUM_SEGS(NUM_SEGS)) u_feed (
    .ser_in    (ser_in),
    .split_mode(split_mode),
    .tap_in    (tap_in),
    .tail_in   (seg_tail[NUM_SEGS-2:0]),
    .seg_head  (seg_head)
  );

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
    segsr_segment #(.SEG_LEN(SEG_LEN)) u_seg (
      .clk(clk),
      .rst(rst),
      .d  (seg_head[g]),
      .q  (seg_q[g])
    );
    assign seg_tail[g] = seg_q[g][SEG_LEN-1];
  end

  assign tap_out = seg_tail;
  assign tap_oe  = {NUM_SEGS{seg_mode_e'(split_mode) == MODE_CHAIN}};

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> tap_out == '0);
  // R2
  head_capture_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> seg_q[0][0] == $past(ser_in));
  // R3
  chain_link_chk: assert property (@(posedge clk) disable iff (rst)
    !split_mode |=> seg_q[1][0] == $past(tap_out[0]));
  // R6
  split_load_chk: assert property (@(posedge clk) disable iff (rst)
    split_mode |=> seg_q[1][0] == $past(tap_in[0]));
  // R5
  split_release_chk: assert property (@(posedge clk)
    split_mode |-> $countones(tap_oe) == 0);
endmodule

// File: tb/seg_shift_chain_bench.sv
module seg_shift_chain_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_in = 1'b0;
  logic       split_mode = 1'b0;
  logic [2:0] tap_in = 3'b000;
  logic [3:0] tap_out;
  logic [3:0] tap_oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct {
    logic [3:0] taps;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  bit ref_st [1:64];

  always #5 clk = ~clk;

  seg_shift_chain u_seg_shift_chain (
    .clk(clk), .rst(rst), .ser_in(ser_in), .split_mode(split_mode),
    .tap_in(tap_in), .tap_out(tap_out), .tap_oe(tap_oe)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: applies one clock of stimulus, updates the reference, queues the expectation
  task automatic step(input bit din, input bit mode, input bit [2:0] tin, input string tag);
    bit nxt [1:64];
    @(negedge clk);
    ser_in = din; split_mode = mode; tap_in = tin;
    #1;
    // R4 R5: enables follow the mode input combinationally
    check(mode ? "R5" : "R4", tap_oe, mode ? 4'b0000 : 4'b1111);
    @(posedge clk);
    nxt[1] = din;
    for (int s = 2; s <= 64; s++) begin
      if (mode && (s == 17 || s == 33 || s == 49)) nxt[s] = tin[(s-17)/16];
      else nxt[s] = ref_st[s-1];
    end
    for (int s = 1; s <= 64; s++) ref_st[s] = nxt[s];
    exp_q.push_back('{{ref_st[64], ref_st[48], ref_st[32], ref_st[16]}, tag});
  endtask

  // Monitor: compares tap outputs at the falling edge after each shift
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.tag, tap_out, e.taps);
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int s = 1; s <= 64; s++) ref_st[s] = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: cleared after reset
    check("R1", tap_out, 4'b0000);

    // R3: single pulse through the full chain, 64-edge delay; R9 tap_in toggling
    step(1'b1, 1'b0, 3'b101, "R3");
    for (int i = 0; i < 70; i++) step(1'b0, 1'b0, 3'(i), "R3");

    // R9: mixed data in chain mode with busy tap inputs
    for (int i = 0; i < 80; i++) step(bit'((i * 7 + (i >> 2)) & 1), 1'b0, 3'(i * 5), "R9");

    // R8: switch to split mid-stream, contents kept
    for (int i = 0; i < 4; i++) step(bit'(i & 1), 1'b1, 3'b000, "R8");

    // R2: pulse on ser_in in split mode reaches tap 16
    step(1'b1, 1'b1, 3'b000, "R2");
    for (int i = 0; i < 18; i++) step(1'b0, 1'b1, 3'b000, "R2");

    // R6 R7: independent segment loading, tap 64 still visible
    for (int i = 0; i < 50; i++)
      step(bit'(i % 3 == 0), 1'b1, {bit'(i % 5 < 2), bit'(i & 1), bit'(i % 4 == 1)}, "R6");
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 3'b111, "R7");

    // R8: back to chain mode, contents kept and linked again
    for (int i = 0; i < 70; i++) step(bit'((i >> 1) & 1), 1'b0, 3'b010, "R8");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule